// File: doc/BRIEF.md
# Multi-class clock sleep controller

This block decides, for up to seventeen functional units, when each unit's clock may be stopped. Each unit is assigned one of three handshake classes when the block is built. An unconditional unit sleeps as soon as software enables it. A unit-requested unit sleeps only while it asks to sleep and software allows it. A controller-initiated unit first receives a sleep-initiate request from the controller, and its clock stops only after it answers with its own request.

Software programs the block through a small register port with a 10-bit address. There is an enable register, a force register and a read-only status register. Each unit owns the same bit position in all three registers. The force register puts a unit to sleep and skips its class handshake. Every sleep output is active-low and comes straight from a flop, so it changes cleanly on the controller clock. The status register shows, one cycle later, which units are asleep.

Top module: `clk_sleep_ctrl`

## Requirements
- R1: While reset is held, the enable register (address 0x0B9) and the force register (address 0x0BA) read 0x00000000. The status register (address 0x0B8) reads 0xFFFF8000. Every `sleepN` bit is 1 and every `sleepInit` bit is 0.
- R2: Unit i uses data bit 31-i in all three registers, so unit 0 is bit 31 and unit 16 is bit 15. Bits 14..0 read 0 and ignore writes. A write to 0x0B8 changes no register. Any unmapped address reads 0.
- R3: For a class 1 unit, `sleepN` goes low on the same clock edge that stores a 1 in its enable bit. It goes high on the edge that clears that bit. No request from the unit is needed.
- R4: For a class 2 unit, `sleepN` is low after an edge exactly when the enable bit is set and `unitReq` is high at that edge. It goes high on the first edge where either of the two is low.
- R5: For a class 3 unit, `sleepInit` rises on the edge that sets the enable bit. `sleepN` goes low only on an edge where `sleepInit` is already high and `unitReq` is high.
- R6: For a class 3 unit, an edge that clears the enable bit drives `sleepInit` low and `sleepN` high together. This holds even when the request rises in the same cycle. If the unit drops `unitReq` while still enabled, `sleepN` goes high and `sleepInit` stays high.
- R7: When a unit's force bit is set, its `sleepN` goes low on the write edge whatever its class, enable or request. For a class 3 unit, `sleepInit` is also held high.
- R8: A status bit reads 1 exactly when the unit's `sleepN` was 0 one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 10 | Register address for both reads and writes |
| regWr | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 32 | Write data, bit 31 belongs to unit 0 |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| unitReq | input | 17 | Sleep request from each unit (class 1 units ignore it) |
| sleepN | output | 17 | Active-low sleep output for each unit, driven from a flop |
| sleepInit | output | 17 | Sleep-initiate request, high only for class 3 units |

## Verification
Two things can land on the same clock edge: a software write to the enable register and a change on a unit's request line. The bench provokes this in two ways. It clears a class 3 unit's enable bit in the same cycle the unit raises its request. It sets a class 2 unit's enable bit in the same cycle the unit drops its request. It judges that no sleep assertion slips through in either case. All other scenarios change one input at a time, and the bench checks each output edge against a count of the registers in the path.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  // Handshake class encoding, two bits per unit in the UNIT_CLASS parameter
  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,  // treated as unconditional
    CLS_UNCOND = 2'd1,
    CLS_REQ    = 2'd2,
    CLS_INIT   = 2'd3
  } cls_e;

  localparam int MAX_UNITS = 32;

  // Decoded register access strobes from control to datapath
  typedef struct packed {
    logic wrEnable;
    logic wrForce;
    logic selEnable;
    logic selForce;
    logic selStatus;
  } strobe_t;

  // Default class map: units cycle through class 1, 2, 3
  function automatic logic [2*MAX_UNITS-1:0] cyclicClasses();
    logic [2*MAX_UNITS-1:0] r;
    r = '0;
    for (int i = 0; i < MAX_UNITS; i++) r[2*i +: 2] = 2'((i % 3) + 1);
    return r;
  endfunction

endpackage

// File: rtl/sleep_ctrl_decode.sv
module sleep_ctrl_decode
  import sleep_ctrl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] ADDR_STATUS = 10'h0B8,
  parameter logic [ADDR_W-1:0] ADDR_ENABLE = 10'h0B9,
  parameter logic [ADDR_W-1:0] ADDR_FORCE  = 10'h0BA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  output strobe_t           strb
);

  always_comb begin
    strb           = '0;
    strb.selEnable = (regAddr == ADDR_ENABLE);
    strb.selForce  = (regAddr == ADDR_FORCE);
    strb.selStatus = (regAddr == ADDR_STATUS);
    strb.wrEnable  = regWr && strb.selEnable;
    strb.wrForce   = regWr && strb.selForce;
  end

  // R2: a single access never reaches more than one register
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.selEnable, strb.selForce, strb.selStatus}));

endmodule

// File: rtl/sleep_ctrl_datapath.sv
module sleep_ctrl_datapath
  import sleep_ctrl_pkg::*;
#(
  parameter int NUM_UNITS = 17,
  parameter int DATA_W    = 32,
  parameter logic [2*MAX_UNITS-1:0] UNIT_CLASS = cyclicClasses()
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              strb,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [NUM_UNITS-1:0] unitReq,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_UNITS-1:0] sleepN,
  output logic [NUM_UNITS-1:0] sleepInit
);

  localparam int RSV_W = DATA_W - NUM_UNITS;

  logic [NUM_UNITS-1:0] enQ, frcQ, enNext, frcNext;
  logic [NUM_UNITS-1:0] sleepQ, initQ, sleepD, initD;
  logic [NUM_UNITS-1:0] statusQ;
  logic                 armedQ;
  logic                 unusedRsv;

  assign unusedRsv = ^regWrData[RSV_W-1:0];

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    localparam int   BIT = DATA_W - 1 - i;
    localparam cls_e CLS = cls_e'(UNIT_CLASS[2*i +: 2]);

    // A write takes effect on its own edge
    assign enNext[i]  = strb.wrEnable ? regWrData[BIT] : enQ[i];
    assign frcNext[i] = strb.wrForce  ? regWrData[BIT] : frcQ[i];

    if (CLS == CLS_REQ) begin : g_req
      assign sleepD[i] = frcNext[i] | (enNext[i] & unitReq[i]);
      assign initD[i]  = 1'b0;

      assert_req_gates_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sleepQ[i] && !frcQ[i]) |-> ($past(unitReq[i]) && enQ[i]));
    end else if (CLS == CLS_INIT) begin : g_init
      assign sleepD[i] = frcNext[i] | (enNext[i] & initQ[i] & unitReq[i]);
      assign initD[i]  = frcNext[i] | enNext[i];

      assert_sleep_after_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sleepQ[i]) && !frcQ[i]) |-> $past(initQ[i]));
      assert_clear_drops_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!enNext[i] && !frcNext[i]) |=> (!sleepQ[i] && !initQ[i]));
    end else begin : g_uncond
      logic unusedReqBit;
      assign unusedReqBit = unitReq[i];
      assign sleepD[i]    = frcNext[i] | enNext[i];
      assign initD[i]     = 1'b0;
    end

    assert_force_sleeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frcNext[i] |=> sleepQ[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enQ     <= '0;
      frcQ    <= '0;
      sleepQ  <= '0;
      initQ   <= '0;
      statusQ <= '1;
      armedQ  <= 1'b0;
    end else begin
      enQ     <= enNext;
      frcQ    <= frcNext;
      sleepQ  <= sleepD;
      initQ   <= initD;
      statusQ <= sleepQ;
      armedQ  <= 1'b1;
    end
  end

  assign sleepN    = ~sleepQ;
  assign sleepInit = initQ;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (strb.selEnable) rdData[DATA_W-1-i] = enQ[i];
      if (strb.selForce)  rdData[DATA_W-1-i] = frcQ[i];
      if (strb.selStatus) rdData[DATA_W-1-i] = statusQ[i];
    end
  end

  // R8: status trails the sleep state by one clock
  assert_status_trails_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armedQ |=> (statusQ == $past(sleepQ)));

endmodule

// File: rtl/clk_sleep_ctrl.sv
module clk_sleep_ctrl
  import sleep_ctrl_pkg::*;
#(
  parameter int NUM_UNITS = 17,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] ADDR_STATUS = 10'h0B8,
  parameter logic [ADDR_W-1:0] ADDR_ENABLE = 10'h0B9,
  parameter logic [ADDR_W-1:0] ADDR_FORCE  = 10'h0BA,
  parameter logic [2*MAX_UNITS-1:0] UNIT_CLASS = cyclicClasses()
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [NUM_UNITS-1:0] unitReq,
  output logic [NUM_UNITS-1:0] sleepN,
  output logic [NUM_UNITS-1:0] sleepInit
);

  strobe_t strb;

  sleep_ctrl_decode #(
    .ADDR_W(ADDR_W), .ADDR_STATUS(ADDR_STATUS),
    .ADDR_ENABLE(ADDR_ENABLE), .ADDR_FORCE(ADDR_FORCE)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWr(regWr), .strb(strb)
  );

  sleep_ctrl_datapath #(
    .NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W), .UNIT_CLASS(UNIT_CLASS)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .regWrData(regWrData),
    .unitReq(unitReq), .rdData(regRdData), .sleepN(sleepN), .sleepInit(sleepInit)
  );

endmodule

// File: tb/clk_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module clk_sleep_ctrl_bench;

  localparam logic [9:0] A_STAT = 10'h0B8, A_EN = 10'h0B9, A_FRC = 10'h0BA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [16:0] unitReq = '0;
  logic [16:0] sleepN, sleepInit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clk_sleep_ctrl u_clk_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .unitReq(unitReq),
    .sleepN(sleepN), .sleepInit(sleepInit)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWr = 1'b1; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #0.5 d = regRdData;
  endtask

  task automatic testReset();
    logic [31:0] d;
    rdReg(A_EN, d);   check("R1 enable at reset", d, 32'h0);
    rdReg(A_FRC, d);  check("R1 force at reset", d, 32'h0);
    rdReg(A_STAT, d); check("R1 status at reset", d, 32'hFFFF_8000);
    check("R1 sleepN at reset", 32'(sleepN), 32'h1FFFF);
    check("R1 sleepInit at reset", 32'(sleepInit), 32'h0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic testMap();
    logic [31:0] d;
    wrReg(A_EN, 32'h0000_FFFF);
    rdReg(A_EN, d);   check("R2 unit16 at bit15, reserved zero", d, 32'h0000_8000);
    wrReg(A_STAT, 32'hFFFF_FFFF);
    rdReg(A_EN, d);   check("R2 status write leaves enable", d, 32'h0000_8000);
    rdReg(A_FRC, d);  check("R2 status write leaves force", d, 32'h0);
    rdReg(10'h0BB, d); check("R2 unmapped reads zero", d, 32'h0);
    wrReg(A_EN, 32'h0);
  endtask

  task automatic testClass1();
    logic [31:0] d;
    wrReg(A_EN, 32'h8000_0000);
    check("R3 class1 sleeps on write edge", 32'(sleepN), 32'h1FFFE);
    check("R3 class1 no initiate", 32'(sleepInit), 32'h0);
    rdReg(A_STAT, d); check("R8 status after class1 sleep", d, 32'h8000_0000);
    wrReg(A_EN, 32'h0);
    check("R3 class1 wakes on clear", 32'(sleepN), 32'h1FFFF);
  endtask

  task automatic testClass2();
    wrReg(A_EN, 32'h4000_0000);
    check("R4 class2 waits for request", 32'(sleepN[1]), 32'h1);
    @(negedge clk) unitReq[1] = 1'b1;
    @(negedge clk);
    check("R4 class2 sleeps on request", 32'(sleepN[1]), 32'h0);
    unitReq[1] = 1'b0;
    @(negedge clk);
    check("R4 class2 wakes on request drop", 32'(sleepN[1]), 32'h1);
    unitReq[1] = 1'b1;
    @(negedge clk);
    check("R4 class2 sleeps again", 32'(sleepN[1]), 32'h0);
    wrReg(A_EN, 32'h0);
    check("R4 class2 wakes on enable clear", 32'(sleepN[1]), 32'h1);
    unitReq[1] = 1'b0;
  endtask

  task automatic testClass3();
    logic [31:0] d;
    wrReg(A_EN, 32'h2000_0000);
    check("R5 class3 initiate on write edge", 32'(sleepInit), 32'h4);
    @(negedge clk);
    check("R5 class3 waits for answer", 32'(sleepN[2]), 32'h1);
    unitReq[2] = 1'b1;
    @(negedge clk);
    check("R5 class3 sleeps after answer", 32'(sleepN[2]), 32'h0);
    rdReg(A_STAT, d); check("R8 status class3", d, 32'h2000_0000);
    unitReq[2] = 1'b0;
    @(negedge clk);
    check("R6 unit ends sleep", {31'h0, sleepN[2]}, 32'h1);
    check("R6 initiate stays", {31'h0, sleepInit[2]}, 32'h1);
    unitReq[2] = 1'b1;
    @(negedge clk);
    check("R5 class3 sleeps again", {31'h0, sleepN[2]}, 32'h0);
    wrReg(A_EN, 32'h0);
    check("R6 clear releases sleep", {31'h0, sleepN[2]}, 32'h1);
    check("R6 clear drops initiate", {31'h0, sleepInit[2]}, 32'h0);
    unitReq[2] = 1'b0;
  endtask

  task automatic testForce();
    logic [31:0] d;
    wrReg(A_FRC, 32'h6000_0000);
    check("R7 force sleeps class2 and class3", 32'(sleepN), 32'h1FFF9);
    check("R7 force holds initiate", 32'(sleepInit), 32'h4);
    rdReg(A_FRC, d); check("R7 force readback", d, 32'h6000_0000);
    wrReg(A_FRC, 32'h0);
    check("R7 force release", 32'(sleepN), 32'h1FFFF);
  endtask

  task automatic testCollide();
    wrReg(A_EN, 32'h2000_0000);
    @(negedge clk);
    regAddr = A_EN; regWr = 1'b1; regWrData = 32'h0; unitReq[2] = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
    check("R6 clear beats request", {31'h0, sleepN[2]}, 32'h1);
    check("R6 clear drops initiate same edge", {31'h0, sleepInit[2]}, 32'h0);
    @(negedge clk);
    check("R6 stays awake after collision", {31'h0, sleepN[2]}, 32'h1);
    unitReq[2] = 1'b0;
    unitReq[1] = 1'b1;
    @(negedge clk);
    regAddr = A_EN; regWr = 1'b1; regWrData = 32'h4000_0000; unitReq[1] = 1'b0;
    @(negedge clk);
    regWr = 1'b0;
    check("R4 enable with dropped request stays awake", {31'h0, sleepN[1]}, 32'h1);
    wrReg(A_EN, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testMap();
    testClass1();
    testClass2();
    testClass3();
    testForce();
    testCollide();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule